// File: doc/BRIEF.md
# Bank machine idle pool allocator

This block hands incoming memory requests to a fixed pool of request-handling machines. Every machine carries a position number. An idle machine's number is its place in the free pool, and a busy machine's number is its place in the queue of requests aimed at the same rank and bank. The allocator keeps every position up to date from cycle to cycle. It raises accept while a machine is free and gives each request to the machine at the front of the free pool. It classifies the offered address against the busy machines and reports where the new request lands in its rank-bank queue. It also reports whether the current tail of that queue already holds the same row.

A machine that has finished its work is returned through a per-machine retire vector. Any number of machines may retire in the same cycle, and each one gets a distinct slot at the back of the free pool. A pending periodic read has priority over user traffic. While it is pending, accept is withdrawn from the user, and the periodic read takes the next free machine in place of any user request offered in that cycle.

Top module: `pool_alloc`

## Requirements
- R1: After reset every machine is idle, machine i holds idle position i, and idle_cnt equals NUM_MACH.
- R2: accept is 1 exactly when idle_cnt is nonzero and no periodic read is pending.
- R3: When a request is taken, grant is one-hot on the idle machine at position 0. That machine is busy in the next cycle, and every other idle machine moves down one position.
- R4: A busy machine that retires becomes idle with position idle_cnt plus the number of lower-numbered busy machines retiring in the same cycle, minus one if a request is taken in that cycle.
- R5: A taken request to a rank-bank that no busy machine holds gets queue position 0. A request to a held rank-bank gets position hit_cnt, minus one if a machine of that queue retires in the same cycle. This value is output as join_pos.
- R6: Retiring is allowed only for a machine at queue position 0. When a machine retires, every other busy machine with the same rank and bank moves down one queue position.
- R7: While prd_pending is 1, a request is taken whenever a machine is free, regardless of req_valid. The machine is loaded with prd_rank, prd_bank and row 0, and the user request is not loaded.
- R8: In every cycle the positions of the idle machines are distinct and each is below idle_cnt.
- R9: hit_cnt is the number of busy machines whose rank and bank equal the offered address (the periodic address while prd_pending is 1, otherwise the user address).
- R10: A retire bit for an idle machine is ignored and changes no position.
- R11: row_hit is 1 when the busy machine at position hit_cnt-1 of the offered rank-bank queue holds the offered row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | User request offered |
| req_rank | input | RANK_W | User request rank |
| req_bank | input | BANK_W | User request bank |
| req_row | input | ROW_W | User request row |
| prd_pending | input | 1 | Periodic read waiting for a machine |
| prd_rank | input | RANK_W | Periodic read rank |
| prd_bank | input | BANK_W | Periodic read bank |
| retire | input | NUM_MACH | Per-machine completion strobe |
| accept | output | 1 | User request may be offered |
| grant | output | NUM_MACH | One-hot: machine taking the request this cycle |
| idle_vec | output | NUM_MACH | Per-machine idle flag |
| idle_cnt | output | CW | Number of idle machines |
| pos_flat | output | NUM_MACH*CW | Position number of each machine, machine i at bits i*CW |
| hit_cnt | output | CW | Busy machines holding the offered rank-bank |
| join_pos | output | CW | Queue position the offered request would take |
| row_hit | output | 1 | Tail of the offered queue holds the offered row |

## Verification
On every cycle the bound checker confirms the following: idle positions stay distinct and within the pool size, accept falls when the pool is empty or a periodic read waits, grant is one-hot on the pool head and that machine leaves the pool, and a retiring machine is idle one cycle later. The exact position values need the bench's scenarios and its reference model. This includes the sums used when several machines retire while a request is taken, the join position when the queue's own head retires, row-hit detection, and the fact that retire strobes on idle machines are ignored.

// File: rtl/pool_alloc_pkg.sv
package pool_alloc_pkg;

  // Population count over a word of up to 32 flags.
  function automatic int unsigned pop32(input logic [31:0] v);
    int unsigned c;
    c = 0;
    for (int k = 0; k < 32; k++) c += 32'(v[k]);
    return c;
  endfunction

endpackage

// File: rtl/pool_slot.sv
module pool_slot #(
  parameter int ID     = 0,
  parameter int CW     = 3,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              ret,
  input  logic              adv,
  input  logic [CW-1:0]     below,
  input  logic [CW-1:0]     idle_cnt,
  input  logic [CW-1:0]     join_pos,
  input  logic [RANK_W-1:0] new_rank,
  input  logic [BANK_W-1:0] new_bank,
  input  logic [ROW_W-1:0]  new_row,
  output logic              idle_o,
  output logic              grant_o,
  output logic [CW-1:0]     pos_o,
  output logic [RANK_W-1:0] rank_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o
);

  logic              idle_q, idle_d;
  logic [CW-1:0]     pos_q, pos_d;
  logic              load;
  logic              head;
  logic [RANK_W-1:0] rank_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;

  assign head    = idle_q && (pos_q == '0);
  assign grant_o = take && head;

  always_comb begin
    idle_d = idle_q;
    pos_d  = pos_q;
    load   = 1'b0;
    if (ret && !idle_q) begin
      idle_d = 1'b1;
      pos_d  = idle_cnt + below - CW'(take);
    end else if (idle_q && take) begin
      if (head) begin
        idle_d = 1'b0;
        pos_d  = join_pos;
        load   = 1'b1;
      end else begin
        pos_d = pos_q - CW'(1);
      end
    end else if (!idle_q && adv) begin
      pos_d = pos_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      pos_q  <= CW'(ID);
    end else begin
      idle_q <= idle_d;
      pos_q  <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= '0;
      bank_q <= '0;
      row_q  <= '0;
    end else if (load) begin
      rank_q <= new_rank;
      bank_q <= new_bank;
      row_q  <= new_row;
    end
  end

  assign idle_o = idle_q;
  assign pos_o  = pos_q;
  assign rank_o = rank_q;
  assign bank_o = bank_q;
  assign row_o  = row_q;

endmodule

// File: rtl/pool_classify.sv
module pool_classify
  import pool_alloc_pkg::*;
#(
  parameter int NUM_MACH = 4,
  parameter int CW       = 3,
  parameter int RANK_W   = 2,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 14
) (
  input  logic [NUM_MACH-1:0]        idle_vec,
  input  logic [NUM_MACH*RANK_W-1:0] rank_flat,
  input  logic [NUM_MACH*BANK_W-1:0] bank_flat,
  input  logic [NUM_MACH*ROW_W-1:0]  row_flat,
  input  logic [NUM_MACH*CW-1:0]     pos_flat,
  input  logic [NUM_MACH-1:0]        ret_vec,
  input  logic [RANK_W-1:0]          off_rank,
  input  logic [BANK_W-1:0]          off_bank,
  input  logic [ROW_W-1:0]           off_row,
  output logic [CW-1:0]              hit_cnt,
  output logic [CW-1:0]              join_pos,
  output logic                       row_hit
);

  logic [NUM_MACH-1:0] match;
  logic                q_ret;

  always_comb begin
    for (int i = 0; i < NUM_MACH; i++) begin
      match[i] = !idle_vec[i] &&
                 (rank_flat[i*RANK_W +: RANK_W] == off_rank) &&
                 (bank_flat[i*BANK_W +: BANK_W] == off_bank);
    end
    hit_cnt  = CW'(pop32(32'(match)));
    q_ret    = |(match & ret_vec);
    join_pos = hit_cnt - CW'(q_ret);
    row_hit  = 1'b0;
    for (int i = 0; i < NUM_MACH; i++) begin
      if (match[i] && (pos_flat[i*CW +: CW] == hit_cnt - CW'(1)) &&
          (row_flat[i*ROW_W +: ROW_W] == off_row))
        row_hit = 1'b1;
    end
  end

endmodule

// File: rtl/pool_alloc.sv
module pool_alloc
  import pool_alloc_pkg::*;
#(
  parameter int NUM_MACH = 4,
  parameter int RANK_W   = 2,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 14,
  localparam int CW      = $clog2(NUM_MACH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [RANK_W-1:0]      req_rank,
  input  logic [BANK_W-1:0]      req_bank,
  input  logic [ROW_W-1:0]       req_row,
  input  logic                   prd_pending,
  input  logic [RANK_W-1:0]      prd_rank,
  input  logic [BANK_W-1:0]      prd_bank,
  input  logic [NUM_MACH-1:0]    retire,
  output logic                   accept,
  output logic [NUM_MACH-1:0]    grant,
  output logic [NUM_MACH-1:0]    idle_vec,
  output logic [CW-1:0]          idle_cnt,
  output logic [NUM_MACH*CW-1:0] pos_flat,
  output logic [CW-1:0]          hit_cnt,
  output logic [CW-1:0]          join_pos,
  output logic                   row_hit
);

  logic [NUM_MACH*RANK_W-1:0] rank_flat;
  logic [NUM_MACH*BANK_W-1:0] bank_flat;
  logic [NUM_MACH*ROW_W-1:0]  row_flat;
  logic [NUM_MACH-1:0]        eff_ret;
  logic [NUM_MACH-1:0]        adv;
  logic                       avail;
  logic                       take;
  logic [RANK_W-1:0]          off_rank;
  logic [BANK_W-1:0]          off_bank;
  logic [ROW_W-1:0]           off_row;

  assign idle_cnt = CW'(pop32(32'(idle_vec)));
  assign avail    = (idle_cnt != '0);
  assign accept   = avail && !prd_pending;
  assign take     = avail && (prd_pending || req_valid);
  assign eff_ret  = retire & ~idle_vec;
  assign off_rank = prd_pending ? prd_rank : req_rank;
  assign off_bank = prd_pending ? prd_bank : req_bank;
  assign off_row  = prd_pending ? '0 : req_row;

  pool_classify #(
    .NUM_MACH(NUM_MACH), .CW(CW), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_classify (
    .idle_vec (idle_vec),
    .rank_flat(rank_flat),
    .bank_flat(bank_flat),
    .row_flat (row_flat),
    .pos_flat (pos_flat),
    .ret_vec  (eff_ret),
    .off_rank (off_rank),
    .off_bank (off_bank),
    .off_row  (off_row),
    .hit_cnt  (hit_cnt),
    .join_pos (join_pos),
    .row_hit  (row_hit)
  );

  for (genvar g = 0; g < NUM_MACH; g++) begin : g_slot
    logic [CW-1:0] below;
    assign below = CW'(pop32(32'(eff_ret) & ((32'd1 << g) - 32'd1)));

    // Another busy machine of the same rank-bank queue retires this cycle.
    always_comb begin
      adv[g] = 1'b0;
      for (int j = 0; j < NUM_MACH; j++) begin
        if (j != g && eff_ret[j] &&
            rank_flat[j*RANK_W +: RANK_W] == rank_flat[g*RANK_W +: RANK_W] &&
            bank_flat[j*BANK_W +: BANK_W] == bank_flat[g*BANK_W +: BANK_W])
          adv[g] = 1'b1;
      end
    end

    pool_slot #(
      .ID(g), .CW(CW), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .ret     (retire[g]),
      .adv     (adv[g]),
      .below   (below),
      .idle_cnt(idle_cnt),
      .join_pos(join_pos),
      .new_rank(off_rank),
      .new_bank(off_bank),
      .new_row (off_row),
      .idle_o  (idle_vec[g]),
      .grant_o (grant[g]),
      .pos_o   (pos_flat[g*CW +: CW]),
      .rank_o  (rank_flat[g*RANK_W +: RANK_W]),
      .bank_o  (bank_flat[g*BANK_W +: BANK_W]),
      .row_o   (row_flat[g*ROW_W +: ROW_W])
    );
  end

endmodule

// File: rtl/pool_alloc_chk.sv
module pool_alloc_chk #(
  parameter int NUM_MACH = 4,
  parameter int CW       = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   prd_pending,
  input logic [NUM_MACH-1:0]    retire,
  input logic                   accept,
  input logic [NUM_MACH-1:0]    grant,
  input logic [NUM_MACH-1:0]    idle_vec,
  input logic [CW-1:0]          idle_cnt,
  input logic [NUM_MACH*CW-1:0] pos_flat
);

  AST_ACCEPT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == '0) |-> !accept); // R2

  AST_ACCEPT_PRD: assert property (@(posedge clk) disable iff (!rst_n)
    prd_pending |-> !accept); // R7

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3

  for (genvar i = 0; i < NUM_MACH; i++) begin : g_m
    AST_GRANT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> (idle_vec[i] && pos_flat[i*CW +: CW] == '0)); // R3

    AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |=> !idle_vec[i]); // R3

    AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (retire[i] && !idle_vec[i]) |=> idle_vec[i]); // R4

    AST_IDLE_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_vec[i] |-> (pos_flat[i*CW +: CW] < idle_cnt)); // R8

    for (genvar j = i + 1; j < NUM_MACH; j++) begin : g_p
      AST_IDLE_POS_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_vec[i] && idle_vec[j]) |->
          (pos_flat[i*CW +: CW] != pos_flat[j*CW +: CW])); // R8
    end
  end

endmodule

bind pool_alloc pool_alloc_chk #(.NUM_MACH(NUM_MACH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prd_pending(prd_pending),
  .retire     (retire),
  .accept     (accept),
  .grant      (grant),
  .idle_vec   (idle_vec),
  .idle_cnt   (idle_cnt),
  .pos_flat   (pos_flat)
);

// File: tb/pool_alloc_tb.sv
`timescale 1ns/1ps
module pool_alloc_tb;
  localparam int N      = 4;
  localparam int RANK_W = 2;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 14;
  localparam int CW     = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [RANK_W-1:0] req_rank = '0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic prd_pending = 1'b0;
  logic [RANK_W-1:0] prd_rank = '0;
  logic [BANK_W-1:0] prd_bank = '0;
  logic [N-1:0] retire = '0;
  logic accept, row_hit;
  logic [N-1:0] grant, idle_vec;
  logic [CW-1:0] idle_cnt, hit_cnt, join_pos;
  logic [N*CW-1:0] pos_flat;

  always #10 clk = ~clk;

  pool_alloc #(.NUM_MACH(N), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rank(req_rank),
    .req_bank(req_bank), .req_row(req_row), .prd_pending(prd_pending),
    .prd_rank(prd_rank), .prd_bank(prd_bank), .retire(retire), .accept(accept),
    .grant(grant), .idle_vec(idle_vec), .idle_cnt(idle_cnt), .pos_flat(pos_flat),
    .hit_cnt(hit_cnt), .join_pos(join_pos), .row_hit(row_hit));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  bit m_idle [N];
  int m_pos  [N];
  int m_rank [N];
  int m_bank [N];
  int m_row  [N];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pool_size();
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m_idle[i]);
    return c;
  endfunction

  function automatic int off_r(); return prd_pending ? int'(prd_rank) : int'(req_rank); endfunction
  function automatic int off_b(); return prd_pending ? int'(prd_bank) : int'(req_bank); endfunction
  function automatic int off_w(); return prd_pending ? 0 : int'(req_row); endfunction

  function automatic int exp_hits();
    int c = 0;
    for (int i = 0; i < N; i++)
      if (!m_idle[i] && m_rank[i] == off_r() && m_bank[i] == off_b()) c++;
    return c;
  endfunction

  function automatic int exp_join();
    int q = 0;
    for (int i = 0; i < N; i++)
      if (!m_idle[i] && retire[i] && m_rank[i] == off_r() && m_bank[i] == off_b()) q = 1;
    return exp_hits() - q;
  endfunction

  function automatic bit exp_rowhit();
    int h = exp_hits();
    for (int i = 0; i < N; i++)
      if (!m_idle[i] && m_rank[i] == off_r() && m_bank[i] == off_b() &&
          m_pos[i] == h - 1 && m_row[i] == off_w()) return 1'b1;
    return 1'b0;
  endfunction

  // State checks: positions, idle flags, pool shape.
  task automatic check_state();
    int cnt = 0;
    for (int i = 0; i < N; i++) begin
      chk("R3 R4 R6 R10 idle flag", int'(idle_vec[i]), int'(m_idle[i]));
      chk("R3 R4 R5 R6 R10 position", int'(pos_flat[i*CW +: CW]), m_pos[i]);
      if (idle_vec[i]) cnt++;
    end
    chk("R8 idle count", int'(idle_cnt), cnt);
    for (int i = 0; i < N; i++) begin
      if (idle_vec[i]) begin
        chk("R8 idle position in range", int'(pos_flat[i*CW +: CW] < idle_cnt), 1);
        for (int j = i + 1; j < N; j++)
          if (idle_vec[j])
            chk("R8 idle positions distinct",
                int'(pos_flat[i*CW +: CW] != pos_flat[j*CW +: CW]), 1);
      end
    end
  endtask

  // Output checks for the applied stimulus, then model update.
  task automatic check_and_step();
    int cnt = pool_size();
    bit tk = (cnt > 0) && (prd_pending || req_valid);
    int jn = exp_join();
    bit eff [N];
    bit n_idle [N];
    int n_pos [N];
    chk("R2 R7 accept", int'(accept), int'(cnt > 0 && !prd_pending));
    chk("R9 hit count", int'(hit_cnt), exp_hits());
    chk("R5 join position", int'(join_pos), jn);
    chk("R11 row hit", int'(row_hit), int'(exp_rowhit()));
    for (int i = 0; i < N; i++)
      chk("R3 R7 grant", int'(grant[i]), int'(tk && m_idle[i] && m_pos[i] == 0));
    for (int i = 0; i < N; i++) eff[i] = retire[i] && !m_idle[i];
    for (int i = 0; i < N; i++) begin
      n_idle[i] = m_idle[i];
      n_pos[i]  = m_pos[i];
      if (eff[i]) begin
        int below = 0;
        for (int j = 0; j < i; j++) below += int'(eff[j]);
        n_idle[i] = 1'b1;
        n_pos[i]  = cnt + below - int'(tk);
      end else if (m_idle[i] && tk) begin
        if (m_pos[i] == 0) begin
          n_idle[i] = 1'b0;
          n_pos[i]  = jn;
          m_rank[i] = off_r();
          m_bank[i] = off_b();
          m_row[i]  = off_w();
        end else n_pos[i] = m_pos[i] - 1;
      end else if (!m_idle[i]) begin
        bit a = 0;
        for (int j = 0; j < N; j++)
          if (j != i && eff[j] && m_rank[j] == m_rank[i] && m_bank[j] == m_bank[i]) a = 1;
        if (a) n_pos[i] = m_pos[i] - 1;
      end
    end
    for (int i = 0; i < N; i++) begin
      m_idle[i] = n_idle[i];
      m_pos[i]  = n_pos[i];
    end
  endtask

  // One cycle: legal retires only from queue heads, plus stray bits on idle machines.
  task automatic cycle(input int p_req, input int p_ret, input int rmax, input int bmax, input int p_prd);
    @(negedge clk);
    check_state();
    req_valid   = ($urandom % 100) < p_req;
    req_rank    = RANK_W'($urandom % rmax);
    req_bank    = BANK_W'($urandom % bmax);
    req_row     = ROW_W'($urandom % 3);
    prd_pending = ($urandom % 100) < p_prd;
    prd_rank    = RANK_W'($urandom % rmax);
    prd_bank    = BANK_W'($urandom % bmax);
    for (int i = 0; i < N; i++)
      retire[i] = m_idle[i] ? (($urandom % 8) == 0)
                            : (m_pos[i] == 0 && ($urandom % 100) < p_ret);
    #1;
    check_and_step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_idle[i] = 1'b1; m_pos[i] = i; m_rank[i] = 0; m_bank[i] = 0; m_row[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 idle count after reset", int'(idle_cnt), N);
    for (int i = 0; i < N; i++) begin
      chk("R1 idle after reset", int'(idle_vec[i]), 1);
      chk("R1 position after reset", int'(pos_flat[i*CW +: CW]), i);
    end
    rst_n = 1'b1;
    // Directed: fill one rank-bank queue, same row (R5 R11), until pool is empty (R2).
    for (int k = 0; k < N + 2; k++) begin
      @(negedge clk);
      check_state();
      req_valid = 1'b1; req_rank = '0; req_bank = 3'd1; req_row = 14'd7;
      prd_pending = 1'b0; retire = '0;
      #1;
      check_and_step();
    end
    // Directed: periodic read with user request while pool empty, then retire head
    // together with a periodic read taking it (R7 R4 R6).
    @(negedge clk);
    check_state();
    prd_pending = 1'b1; prd_rank = '0; prd_bank = 3'd1; req_valid = 1'b1;
    for (int i = 0; i < N; i++) retire[i] = !m_idle[i] && m_pos[i] == 0;
    #1; check_and_step();
    @(negedge clk);
    check_state();
    retire = '0; req_valid = 1'b1; req_bank = 3'd2;
    #1; check_and_step();
    // Random phases: deep queues, heavy retire, mixed traffic.
    for (int k = 0; k < 800; k++) cycle(80, 30, 1, 2, 5);
    for (int k = 0; k < 800; k++) cycle(20, 90, 2, 2, 10);
    for (int k = 0; k < 2000; k++) cycle(60, 50, 4, 8, 15);
    req_valid = 1'b0; prd_pending = 1'b0; retire = '0;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule